// File: doc/BRIEF.md
# Load-Store Effective Address Generator

This block turns the addressing fields of a load/store instruction into the memory address or addresses to access, and into the new value of any address register that the instruction modifies. The instruction carries a 10-bit offset, a base register value A[b], and for the two buffer-oriented modes also the adjoining register A[b+1]. Five addressing modes are supported. Three are linear: a plain displacement, an update of the base after the access, and an update of the base before the access. The other two walk through a buffer: a circular buffer, and a bit-reversed sweep.

In the circular mode, A[b+1] is a packed pair. Its low half is the current index and its high half is the buffer length in bytes. The block wraps both the second word of a 64-bit access and the updated index so that they stay inside the buffer. The bit-reversed index update is computed outside this block and is presented on its own input. The result is registered, so every request produces its outputs one clock later. Address-only operations, such as cache maintenance with an increment mode, use the same path and receive the same base update.

Top module: `ea_gen`

## Requirements
- R1: Outputs appear one clock after the request. `out_valid` equals `req_valid` delayed by one cycle. While `rst` is high, `out_valid`, `base_we` and `pair_we` are 0.
- R2: The 10-bit offset is a two's-complement value with bit 9 as its sign. It is sign-extended to 32 bits before any addition.
- R3: Mode code 0 (displacement): `addr0` = base + offset. Neither write enable is set.
- R4: Mode code 1 (update after): `addr0` = base. `base_we` = 1 and `base_new` = base + offset.
- R5: Mode code 2 (update before): `addr0` = base + offset. `base_we` = 1 and `base_new` equals that same address.
- R6: For a 64-bit access in modes 0, 1, 2 and the reserved codes, `addr1` = `addr0` + 4.
- R7: Mode codes 3 (circular) and 4 (bit-reversed): `addr0` = base + the zero-extended bits [15:0] of the pair register. `base_we` = 0 and `pair_we` = 1.
- R8: In circular mode, the new index is index + offset. When that sum is negative, the length is added to it. When the sum is greater than or equal to the length, the length is subtracted from it. A length of 0 means no wrap, so the sum is taken modulo 2^16. Bits [31:16] of `pair_new` keep the length.
- R9: For a 64-bit circular access, `addr1` = base + the index wrapped by the R8 rule after adding 4 to it.
- R10: In bit-reversed mode, `pair_new` equals the `brev_next` input. For a 64-bit access, `addr1` = `addr0` + 4.
- R11: The reserved mode codes 5 to 7 behave like mode 0: the address is base + offset and there is no write-back.
- R12: A cycle with `req_valid` low gives no write enable in the following cycle, whatever the mode input holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_wide | input | 1 | 64-bit (two-word) access |
| req_off | input | 10 | Raw signed offset field |
| base_a | input | 32 | Base register A[b] |
| pair_a | input | 32 | Paired register A[b+1]: {length, index} |
| brev_next | input | 32 | Externally computed bit-reversed update of A[b+1] |
| out_valid | output | 1 | Result valid |
| addr0 | output | 32 | First-word address |
| addr1 | output | 32 | Second-word address |
| base_we | output | 1 | Write `base_new` into A[b] |
| base_new | output | 32 | New A[b] value |
| pair_we | output | 1 | Write `pair_new` into A[b+1] |
| pair_new | output | 32 | New A[b+1] value |

## Verification
The two functions that can coincide are the second-word wrap of a 64-bit circular access and the wrap of the updated index. Both can cross the end of the buffer in the same cycle. The bench provokes this with an index just below the length, a positive offset and a wide access. It then checks that `addr1` lands near the buffer start and that `pair_new` wraps independently with the same length. A behavioural reference model predicts every field on every clock. Random stimulus keeps circular requests within the length precondition.

// File: rtl/ea_pkg.sv
package ea_pkg;
    localparam int ADDR_W     = 32;
    localparam int OFF_W      = 10;
    localparam int IDX_W      = 16;
    localparam int LEN_W      = ADDR_W - IDX_W;
    localparam int BEAT_BYTES = 4;
    localparam int SUM_W      = IDX_W + 2;

    typedef enum logic [2:0] {
        AM_SHORT = 3'd0,
        AM_POST  = 3'd1,
        AM_PRE   = 3'd2,
        AM_CIRC  = 3'd3,
        AM_BREV  = 3'd4
    } am_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr0;
        logic [ADDR_W-1:0] addr1;
        logic              base_we;
        logic [ADDR_W-1:0] base_new;
        logic              pair_we;
        logic [ADDR_W-1:0] pair_new;
    } ea_res_t;

    // Sign-extend the raw offset field to the address width.
    function automatic logic [ADDR_W-1:0] sext_off(input logic [OFF_W-1:0] f);
        return {{(ADDR_W-OFF_W){f[OFF_W-1]}}, f};
    endfunction

    // Sign-extend the offset field to the width used for index arithmetic.
    function automatic logic signed [SUM_W-1:0] off_delta(input logic [OFF_W-1:0] f);
        return {{(SUM_W-OFF_W){f[OFF_W-1]}}, f};
    endfunction

    // Move an index by a signed delta inside a buffer of length len.
    // A single correction step is applied; len == 0 disables wrapping.
    function automatic logic [IDX_W-1:0] wrap_idx(
        input logic [IDX_W-1:0]        idx,
        input logic signed [SUM_W-1:0] delta,
        input logic [LEN_W-1:0]        len
    );
        logic signed [SUM_W-1:0] s;
        logic signed [SUM_W-1:0] lx;
        logic signed [SUM_W-1:0] r;
        lx = $signed({{(SUM_W-LEN_W){1'b0}}, len});
        s  = $signed({{(SUM_W-IDX_W){1'b0}}, idx}) + delta;
        if (len == '0)
            r = s;
        else if (s < 0)
            r = s + lx;
        else if (s >= lx)
            r = s - lx;
        else
            r = s;
        return r[IDX_W-1:0];
    endfunction
endpackage

// File: rtl/ea_linear_unit.sv
module ea_linear_unit
    import ea_pkg::*;
(
    input  am_e                mode,
    input  logic [ADDR_W-1:0]  base,
    input  logic [OFF_W-1:0]   off,
    output logic [ADDR_W-1:0]  addr,
    output logic               wb_en,
    output logic [ADDR_W-1:0]  wb_val
);
    logic [ADDR_W-1:0] sum;

    assign sum    = base + sext_off(off);
    assign wb_val = sum;

    always_comb begin
        case (mode)
            AM_POST: begin
                addr  = base;
                wb_en = 1'b1;
            end
            AM_PRE: begin
                addr  = sum;
                wb_en = 1'b1;
            end
            default: begin
                addr  = sum;
                wb_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ea_circ_unit.sv
module ea_circ_unit
    import ea_pkg::*;
(
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] pair,
    input  logic [OFF_W-1:0]  off,
    output logic [ADDR_W-1:0] addr0,
    output logic [ADDR_W-1:0] addr1,
    output logic [ADDR_W-1:0] pair_upd
);
    localparam logic signed [SUM_W-1:0] BEAT_DELTA = SUM_W'(BEAT_BYTES);

    logic [IDX_W-1:0] idx;
    logic [LEN_W-1:0] len;
    logic [IDX_W-1:0] idx_second;
    logic [IDX_W-1:0] idx_next;

    assign idx = pair[IDX_W-1:0];
    assign len = pair[ADDR_W-1:IDX_W];

    assign idx_second = wrap_idx(idx, BEAT_DELTA, len);
    assign idx_next   = wrap_idx(idx, off_delta(off), len);

    assign addr0    = base + {{(ADDR_W-IDX_W){1'b0}}, idx};
    assign addr1    = base + {{(ADDR_W-IDX_W){1'b0}}, idx_second};
    assign pair_upd = {len, idx_next};
endmodule

// File: rtl/ea_gen.sv
module ea_gen
    import ea_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_mode,
    input  logic              req_wide,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [ADDR_W-1:0] base_a,
    input  logic [ADDR_W-1:0] pair_a,
    input  logic [ADDR_W-1:0] brev_next,
    output logic              out_valid,
    output logic [ADDR_W-1:0] addr0,
    output logic [ADDR_W-1:0] addr1,
    output logic              base_we,
    output logic [ADDR_W-1:0] base_new,
    output logic              pair_we,
    output logic [ADDR_W-1:0] pair_new
);
    am_e               mode_c;
    logic              is_ring;
    logic [ADDR_W-1:0] lin_addr, lin_wb_val;
    logic              lin_wb;
    logic [ADDR_W-1:0] ring_addr0, ring_addr1, ring_pair;
    ea_res_t           nxt, res_q;
    logic              valid_q;

    assign mode_c  = am_e'(req_mode);
    assign is_ring = (mode_c == AM_CIRC) || (mode_c == AM_BREV);

    ea_linear_unit u_lin (
        .mode   (mode_c),
        .base   (base_a),
        .off    (req_off),
        .addr   (lin_addr),
        .wb_en  (lin_wb),
        .wb_val (lin_wb_val)
    );

    ea_circ_unit u_circ (
        .base     (base_a),
        .pair     (pair_a),
        .off      (req_off),
        .addr0    (ring_addr0),
        .addr1    (ring_addr1),
        .pair_upd (ring_pair)
    );

    always_comb begin
        nxt.addr0    = is_ring ? ring_addr0 : lin_addr;
        nxt.addr1    = (mode_c == AM_CIRC) ? ring_addr1
                                           : nxt.addr0 + ADDR_W'(BEAT_BYTES);
        nxt.base_we  = req_valid && !is_ring && lin_wb;
        nxt.base_new = lin_wb_val;
        nxt.pair_we  = req_valid && is_ring;
        nxt.pair_new = (mode_c == AM_CIRC) ? ring_pair : brev_next;
        if (!req_wide)
            nxt.addr1 = res_q.addr1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            res_q   <= '0;
        end else begin
            valid_q <= req_valid;
            res_q   <= nxt;
        end
    end

    assign out_valid = valid_q;
    assign addr0     = res_q.addr0;
    assign addr1     = res_q.addr1;
    assign base_we   = res_q.base_we;
    assign base_new  = res_q.base_new;
    assign pair_we   = res_q.pair_we;
    assign pair_new  = res_q.pair_new;
endmodule

// File: rtl/ea_gen_chk.sv
module ea_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [2:0]  req_mode,
    input logic [9:0]  req_off,
    input logic [31:0] base_a,
    input logic [31:0] pair_a,
    input logic [31:0] brev_next,
    input logic        out_valid,
    input logic [31:0] addr0,
    input logic        base_we,
    input logic [31:0] base_new,
    input logic        pair_we,
    input logic [31:0] pair_new
);
    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        armed |-> out_valid == $past(req_valid));

    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!base_we && !pair_we));

    a_r3_short_addr: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid && req_mode == 3'd0)) |->
        (!base_we && !pair_we &&
         addr0 == $past(base_a + {{22{req_off[9]}}, req_off})));

    a_r4_post_update: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid && req_mode == 3'd1)) |->
        (base_we && addr0 == $past(base_a) &&
         (base_new - addr0) == $past({{22{req_off[9]}}, req_off})));

    a_r5_pre_same: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid && req_mode == 3'd2)) |->
        (base_we && base_new == addr0));

    a_r7_ring_base_kept: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid && (req_mode == 3'd3 || req_mode == 3'd4))) |->
        (!base_we && pair_we &&
         addr0 == $past(base_a + {16'h0, pair_a[15:0]})));

    a_r8_len_kept: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid && req_mode == 3'd3)) |->
        pair_new[31:16] == $past(pair_a[31:16]));

    a_r10_brev_pass: assert property (@(posedge clk) disable iff (rst)
        (armed && $past(req_valid && req_mode == 3'd4)) |->
        pair_new == $past(brev_next));
endmodule

bind ea_gen ea_gen_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_mode  (req_mode),
    .req_off   (req_off),
    .base_a    (base_a),
    .pair_a    (pair_a),
    .brev_next (brev_next),
    .out_valid (out_valid),
    .addr0     (addr0),
    .base_we   (base_we),
    .base_new  (base_new),
    .pair_we   (pair_we),
    .pair_new  (pair_new)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = 3'd0;
    logic        req_wide = 1'b0;
    logic [9:0]  req_off = 10'd0;
    logic [31:0] base_a = 32'd0;
    logic [31:0] pair_a = 32'd0;
    logic [31:0] brev_next = 32'd0;
    logic        out_valid, base_we, pair_we;
    logic [31:0] addr0, addr1, base_new, pair_new;

    int n_run  = 0;
    int n_fail = 0;
    int cycles = 0;

    logic        e_valid, e_wide, e_bwe, e_pwe;
    logic [2:0]  e_mode;
    logic [31:0] e_a0, e_a1, e_bnew, e_pnew;

    always #(CLK_PERIOD/2) clk = ~clk;

    ea_gen uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_wide(req_wide), .req_off(req_off), .base_a(base_a),
        .pair_a(pair_a), .brev_next(brev_next), .out_valid(out_valid),
        .addr0(addr0), .addr1(addr1), .base_we(base_we), .base_new(base_new),
        .pair_we(pair_we), .pair_new(pair_new)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic int ring_step(input int i, input int d, input int l);
        int s;
        s = i + d;
        if (l == 0) return s & 32'hFFFF;
        if (s < 0) return s + l;
        if (s >= l) return s - l;
        return s;
    endfunction

    // Reference model: expectation for the request now on the inputs.
    task automatic predict();
        int so, idx, len;
        so  = req_off[9] ? int'(req_off) - 1024 : int'(req_off);
        idx = int'(pair_a[15:0]);
        len = int'(pair_a[31:16]);
        e_valid = req_valid;
        e_mode  = req_mode;
        e_wide  = req_wide;
        e_bwe   = 1'b0;
        e_pwe   = 1'b0;
        e_bnew  = base_a + 32'(so);
        e_pnew  = 32'd0;
        case (req_mode)
            3'd1: begin e_a0 = base_a; e_bwe = req_valid; end
            3'd2: begin e_a0 = base_a + 32'(so); e_bwe = req_valid; end
            3'd3: begin
                e_a0   = base_a + 32'(idx);
                e_pwe  = req_valid;
                e_pnew = {pair_a[31:16], 16'(ring_step(idx, so, len))};
            end
            3'd4: begin
                e_a0   = base_a + 32'(idx);
                e_pwe  = req_valid;
                e_pnew = brev_next;
            end
            default: e_a0 = base_a + 32'(so);
        endcase
        if (req_mode == 3'd3)
            e_a1 = base_a + 32'(16'(ring_step(idx, 4, len)));
        else
            e_a1 = e_a0 + 32'd4;
    endtask

    task automatic compare();
        string tag;
        chk("R1", "out_valid", {31'd0, out_valid}, {31'd0, e_valid});
        if (!e_valid) begin
            chk("R12", "idle write enables", {30'd0, base_we, pair_we}, 32'd0);
            return;
        end
        case (e_mode)
            3'd0: tag = "R3";
            3'd1: tag = "R4";
            3'd2: tag = "R5";
            3'd3: tag = "R8";
            3'd4: tag = "R10";
            default: tag = "R11";
        endcase
        // R7: buffer modes address from base plus index and never touch base
        chk((e_mode == 3'd3 || e_mode == 3'd4) ? "R7" : tag, "addr0", addr0, e_a0);
        chk(tag, "write enables", {30'd0, base_we, pair_we}, {30'd0, e_bwe, e_pwe});
        if (e_bwe) chk(tag, "base_new", base_new, e_bnew);
        if (e_pwe) chk(tag, "pair_new", pair_new, e_pnew);
        if (e_wide)
            chk(e_mode == 3'd3 ? "R9" : (e_mode == 3'd4 ? "R10" : "R6"),
                "addr1", addr1, e_a1);
    endtask

    task automatic apply(input logic v, input logic [2:0] m, input logic w,
                         input logic [9:0] o, input logic [31:0] b,
                         input logic [31:0] p, input logic [31:0] br);
        req_valid = v; req_mode = m; req_wide = w; req_off = o;
        base_a = b; pair_a = p; brev_next = br;
        predict();
        @(negedge clk);
        compare();
    endtask

    initial begin
        req_valid = 1'b1;
        req_mode  = 3'd1;
        repeat (3) @(negedge clk);
        chk("R1", "reset outputs", {29'd0, out_valid, base_we, pair_we}, 32'd0);
        rst = 1'b0;
        req_valid = 1'b0;
        predict();
        @(negedge clk);
        compare();

        // R2: all-ones offset field is -1
        apply(1, 3'd2, 0, 10'h3FF, 32'h0000_1000, 32'd0, 32'd0);
        // R2: most negative offset, update after
        apply(1, 3'd1, 1, 10'h200, 32'h0000_2000, 32'd0, 32'd0);
        // largest positive offset, displacement, wide
        apply(1, 3'd0, 1, 10'h1FF, 32'h8000_0000, 32'd0, 32'd0);
        // R8/R9 together: index and second word both wrap forward
        apply(1, 3'd3, 1, 10'd4, 32'h0001_0000, {16'd16, 16'd14}, 32'd0);
        // R8: negative step wraps backward
        apply(1, 3'd3, 0, 10'h3FB, 32'h0001_0000, {16'd16, 16'd2}, 32'd0);
        // R8: length zero, index wraps modulo 2^16
        apply(1, 3'd3, 1, 10'd3, 32'h0000_0100, {16'd0, 16'hFFFE}, 32'd0);
        // R10: bit-reversed update passes through
        apply(1, 3'd4, 1, 10'd7, 32'h0000_4000, {16'd64, 16'd8}, 32'hABCD_0020);
        // R11: reserved code
        apply(1, 3'd6, 1, 10'd8, 32'h0000_0300, 32'd0, 32'd0);
        // R12: idle with a writing mode on the inputs
        apply(0, 3'd2, 0, 10'd8, 32'h0000_0300, 32'd0, 32'd0);

        for (int k = 0; k < 400; k++) begin
            logic [2:0]  m;
            logic [31:0] p;
            int          len, idx, o, lim;
            m   = 3'($urandom_range(0, 7));
            len = int'($urandom_range(8, 2000));
            idx = int'($urandom_range(0, len - 1));
            lim = (len < 511) ? len : 511;
            o   = int'($urandom_range(0, 2 * lim)) - lim;
            p   = (m == 3'd3) ? {16'(len), 16'(idx)} : $urandom;
            apply(1'($urandom_range(0, 3) != 0), m, 1'($urandom_range(0, 1)),
                  10'(o), $urandom, p, $urandom);
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule